// File: doc/BRIEF.md
# Threshold-Paced Byte Buffer with Tail Drain Events

This block sits between a host and a serial bus engine. It holds a receive FIFO that the bus engine fills and the host empties, and a transmit FIFO that the host fills and the bus engine empties. Each FIFO has its own programmable threshold. The block raises a level request while a full threshold of work is available, so that the host can move data in threshold-sized bursts.

A transfer whose length is not a whole number of thresholds leaves a short tail. On the receive side, the tail is the data still buffered when the bus engine strobes end-of-transfer. On the transmit side, in controller mode, the tail is the programmed byte count modulo the threshold. When a tail appears, the block raises a sticky drain event, and it reports exact counts so that the host moves only the bytes that remain. A host read of an empty receive FIFO, or a host write to a full transmit FIFO, is not carried out and sets a sticky access-error bit.

Top module: `xbuf_top`

## Requirements
- R1: The receive threshold is CFG[5:0]+1 and the transmit threshold is CFG[13:8]+1 (CFG at address 0). Raw status bit 0 (address 4) is high exactly while the receive fill is at or above the receive threshold.
- R2: Raw status bit 1 is high exactly while the transmit FIFO free space is at or above the transmit threshold and the remaining byte count is also at or above it.
- R3: Each FIFO holds 32 bytes and preserves order. The host writes and reads bytes at DATA (address 2, bits [7:0]). The bus engine pushes with rx_push and pops with tx_pop.
- R4: When xfer_end is strobed while the receive fill is above zero and below the receive threshold, raw bit 2 is set. It is not set otherwise, including when the fill is zero.
- R5: With CFG[16]=1 (controller mode), raw bit 3 is set when the remaining count reaches the nonzero value (count mod transmit threshold), where the count is loaded at COUNT (address 1). No transmit drain occurs when that value is zero or when CFG[16]=0.
- R6: A write to COUNT loads the 16-bit remaining count. Each accepted DATA write decrements it, with a floor at zero. STAT (address 3) reads [5:0] receive fill, [13:8] remaining count saturated at 63, and [31:16] remaining count.
- R7: A DATA read with an empty receive FIFO returns 0 and pops nothing. A DATA write with a full transmit FIFO is dropped. Either access sets raw bit 4.
- R8: Raw bits 2 to 4 are sticky. Writing 1 to a bit at address 4 clears it, and a new event in the same cycle takes priority over the clear.
- R9: The enable register (address 5, bits [4:0]) resets to 0. irq is high exactly when some raw bit and its enable are both 1.
- R10: Writing CFG with bit 31 set empties both FIFOs and leaves the remaining count unchanged.
- R11: After reset, the raw status, the enables, the configuration and the counts all read 0, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| irq | output | 1 | Enabled status interrupt |
| rx_push | input | 1 | Bus engine pushes a received byte |
| rx_byte | input | 8 | Received byte |
| rx_full | output | 1 | Receive FIFO full |
| tx_pop | input | 1 | Bus engine takes a byte to send |
| tx_byte | output | 8 | Byte at the head of the transmit FIFO |
| tx_empty | output | 1 | Transmit FIFO empty |
| xfer_end | input | 1 | End-of-transfer strobe from the bus engine |

## Verification
The hardest state to reach is the transmit drain. It needs controller mode, a count that is not a multiple of the threshold, and host writes in whole thresholds until the remaining count lands exactly on the tail. The bench picks random thresholds and counts from a fixed seed and writes threshold-sized chunks. It pops the bus side between chunks to keep space free, and it predicts the drain bit at every chunk boundary. Directed rounds cover lengths that are exact multiples, target mode, and a receive end-of-transfer with an empty FIFO.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;
  localparam int THR_W = 6;
  localparam int CNT_W = 16;
  localparam int N_EV  = 5;

  typedef enum logic [2:0] {
    A_CFG = 3'd0, A_COUNT = 3'd1, A_DATA = 3'd2,
    A_STAT = 3'd3, A_RAW = 3'd4, A_EN = 3'd5
  } xbuf_addr_e;

  // threshold from its minus-one field
  function automatic logic [THR_W:0] thr_of(input logic [THR_W-1:0] m1);
    return {1'b0, m1} + 1'b1;
  endfunction

  // transfer tail: count modulo threshold
  function automatic logic [THR_W:0] tail_of(input logic [CNT_W-1:0] cnt,
                                             input logic [THR_W-1:0] m1);
    logic [CNT_W-1:0] r;
    r = cnt % {{(CNT_W-THR_W-1){1'b0}}, thr_of(m1)};
    return r[THR_W:0];
  endfunction

  // remaining count clipped to a 6-bit field
  function automatic logic [THR_W-1:0] sat_field(input logic [CNT_W-1:0] v);
    return (v > CNT_W'((1 << THR_W) - 1)) ? {THR_W{1'b1}} : v[THR_W-1:0];
  endfunction
endpackage

// File: rtl/xbuf_fifo.sv
module xbuf_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] fill,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (fill == CW'(DEPTH));
  assign empty   = (fill == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/xbuf_sticky.sv
module xbuf_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/xbuf_top.sv
module xbuf_top
  import xbuf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int FILL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [2:0]        host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              irq,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              rx_full,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_empty,
  input  logic              xfer_end
);
  localparam logic [THR_W:0] DEPTH_T = (THR_W + 1)'(DEPTH);

  logic [THR_W-1:0]  cfg_rx_m1, cfg_tx_m1;
  logic              cfg_ctl;
  logic [N_EV-1:0]   en_q, raw;
  logic [CNT_W-1:0]  tx_left;
  logic [THR_W:0]    tail_q, rx_thr, tx_thr, tx_free;
  logic              tcond, tcond_q;

  logic wr_cfg, wr_count, wr_data, wr_raw, wr_en, rd_data, flush;
  logic [FILL_W-1:0] rx_fill, tx_fill;
  logic [DATA_W-1:0] rx_head;
  logic              rx_empty, tx_full;
  logic              ev_rxreq, ev_txreq, ev_rxdrn, ev_txdrn, ev_aerr;
  logic [2:0]        sticky_q;

  assign wr_cfg   = host_wr && host_addr == A_CFG;
  assign wr_count = host_wr && host_addr == A_COUNT;
  assign wr_data  = host_wr && host_addr == A_DATA;
  assign wr_raw   = host_wr && host_addr == A_RAW;
  assign wr_en    = host_wr && host_addr == A_EN;
  assign rd_data  = host_rd && host_addr == A_DATA;
  assign flush    = wr_cfg && host_wdata[31];

  xbuf_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_push), .din(rx_byte), .pop(rd_data),
    .dout(rx_head), .fill(rx_fill), .full(rx_full), .empty(rx_empty));

  xbuf_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(wr_data), .din(host_wdata[DATA_W-1:0]), .pop(tx_pop),
    .dout(tx_byte), .fill(tx_fill), .full(tx_full), .empty(tx_empty));

  assign rx_thr  = thr_of(cfg_rx_m1);
  assign tx_thr  = thr_of(cfg_tx_m1);
  assign tx_free = DEPTH_T - (THR_W + 1)'(tx_fill);

  // named internal events
  assign ev_rxreq = (THR_W + 1)'(rx_fill) >= rx_thr;
  assign ev_txreq = (tx_free >= tx_thr) && (tx_left >= CNT_W'(tx_thr));
  assign ev_rxdrn = xfer_end && !rx_empty && ((THR_W + 1)'(rx_fill) < rx_thr);
  assign tcond    = cfg_ctl && (tail_q != '0) && (tx_left == CNT_W'(tail_q));
  assign ev_txdrn = tcond && !tcond_q;
  assign ev_aerr  = (rd_data && rx_empty) || (wr_data && tx_full);

  xbuf_sticky #(.N(3)) u_sticky (
    .clk(clk), .rst_n(rst_n),
    .set({ev_aerr, ev_txdrn, ev_rxdrn}),
    .clr(wr_raw ? host_wdata[4:2] : 3'b000),
    .q(sticky_q));

  assign raw = {sticky_q, ev_txreq, ev_rxreq};
  assign irq = |(raw & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rx_m1 <= '0;
      cfg_tx_m1 <= '0;
      cfg_ctl   <= 1'b0;
      en_q      <= '0;
      tx_left   <= '0;
      tail_q    <= '0;
      tcond_q   <= 1'b0;
    end else begin
      if (wr_cfg) begin
        cfg_rx_m1 <= host_wdata[5:0];
        cfg_tx_m1 <= host_wdata[13:8];
        cfg_ctl   <= host_wdata[16];
      end
      if (wr_en) en_q <= host_wdata[N_EV-1:0];
      if (wr_count) begin
        tx_left <= host_wdata[CNT_W-1:0];
        tail_q  <= tail_of(host_wdata[CNT_W-1:0], cfg_tx_m1);
      end else if (wr_data && !tx_full && tx_left != '0) begin
        tx_left <= tx_left - 1'b1;
      end
      tcond_q <= wr_count ? 1'b0 : tcond;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_CFG:   host_rdata = {15'd0, cfg_ctl, 2'd0, cfg_tx_m1, 2'd0, cfg_rx_m1};
      A_COUNT: host_rdata = {16'd0, tx_left};
      A_DATA:  host_rdata = rx_empty ? 32'd0 : {{(32-DATA_W){1'b0}}, rx_head};
      A_STAT:  host_rdata = {tx_left, 2'd0, sat_field(tx_left), 2'd0, THR_W'(rx_fill)};
      A_RAW:   host_rdata = {{(32-N_EV){1'b0}}, raw};
      A_EN:    host_rdata = {{(32-N_EV){1'b0}}, en_q};
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xbuf_chk.sv
module xbuf_chk #(
  parameter int DEPTH = 32,
  localparam int FILL_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [2:0]        host_addr,
  input logic [31:0]       host_wdata,
  input logic              xfer_end,
  input logic              irq,
  input logic [FILL_W-1:0] rx_fill,
  input logic [FILL_W-1:0] tx_fill,
  input logic              rx_empty,
  input logic [6:0]        rx_thr,
  input logic [4:0]        raw,
  input logic [4:0]        en_q,
  input logic [15:0]       tx_left
);
  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rx_fill) <= DEPTH && int'(tx_fill) <= DEPTH);

  // R7
  empty_read_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd2 && rx_empty) |=> raw[4]);

  // R4
  rx_drain_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && rx_fill != '0 && int'(rx_fill) < int'(rx_thr)) |=> raw[2]);

  // R4
  rx_drain_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw[2]) |-> $past(xfer_end));

  // R8
  aerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[4] && !(host_wr && host_addr == 3'd4 && host_wdata[4])) |=> raw[4]);

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0));

  // R6
  left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |=> $stable(tx_left));
endmodule

bind xbuf_top xbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .xfer_end(xfer_end),
  .irq(irq), .rx_fill(rx_fill), .tx_fill(tx_fill), .rx_empty(rx_empty),
  .rx_thr(rx_thr), .raw(raw), .en_q(en_q), .tx_left(tx_left));

// File: tb/sim_xbuf_top.sv
module sim_xbuf_top;
  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0;
  logic [2:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic irq, rx_push = 0, rx_full, tx_pop = 0, tx_empty, xfer_end = 0;
  logic [7:0] rx_byte = 0, tx_byte;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int unsigned seed_v;
  logic [31:0] rd;
  logic [7:0] rxq[$], txq[$];

  always #10 clk = ~clk;

  xbuf_top u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); host_rd = 1; host_addr = a; #2 d = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic bpush(input logic [7:0] b);
    @(negedge clk); rx_push = 1; rx_byte = b;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic bpop(output logic [7:0] b);
    @(negedge clk); tx_pop = 1; #2 b = tx_byte;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic bend();
    @(negedge clk); xfer_end = 1;
    @(negedge clk); xfer_end = 0;
  endtask

  function automatic int thr(input int m1); return m1 + 1; endfunction
  function automatic int tailv(input int cnt, input int m1); return cnt % (m1 + 1); endfunction
  function automatic int sat63(input int v); return v > 63 ? 63 : v; endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // receive round: push n bytes, drain in threshold bursts, end transfer
  task automatic rx_round(input int m1, input int n);
    int t = thr(m1);
    logic [7:0] b;
    hwr(3'd0, {26'd0, m1[5:0]});
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      rxq.push_back(b);
      bpush(b);
    end
    hrd(3'd4, rd);
    check("R1 rx request level", {31'd0, rd[0]}, {31'd0, (n >= t)});
    while (rxq.size() >= t) begin
      for (int i = 0; i < t; i++) begin
        hrd(3'd2, rd);
        check("R3 rx order", rd, {24'd0, rxq.pop_front()});
      end
    end
    hrd(3'd3, rd);
    check("R6 rx fill field", {26'd0, rd[5:0]}, rxq.size());
    bend();
    hrd(3'd4, rd);
    check("R4 rx drain event", {31'd0, rd[2]}, {31'd0, (rxq.size() != 0)});
    while (rxq.size() > 0) begin
      hrd(3'd2, rd);
      check("R3 rx tail order", rd, {24'd0, rxq.pop_front()});
    end
    hwr(3'd4, 32'h1c);
    hrd(3'd4, rd);
    check("R8 w1c clears sticky", {29'd0, rd[4:2]}, 0);
  endtask

  // transmit round in controller mode with chunked host writes
  task automatic tx_round(input int m1, input int cnt);
    int t = thr(m1), tl = tailv(cnt, m1), left = cnt, chunk;
    logic [7:0] b;
    hwr(3'd0, {15'd0, 1'b1, 2'd0, m1[5:0], 8'd0});
    hwr(3'd1, cnt);
    while (left > 0) begin
      hrd(3'd4, rd);
      check("R2 tx request level", {31'd0, rd[1]}, {31'd0, (left >= t)});
      check("R5 tx drain at tail", {31'd0, rd[3]}, {31'd0, (tl != 0 && left == tl)});
      hrd(3'd3, rd);
      check("R6 tx left field", {26'd0, rd[13:8]}, sat63(left));
      check("R6 tx left count", {16'd0, rd[31:16]}, left);
      chunk = (left >= t) ? t : left;
      for (int i = 0; i < chunk; i++) begin
        b = 8'($urandom);
        txq.push_back(b);
        hwr(3'd2, {24'd0, b});
      end
      left -= chunk;
      while (txq.size() > 0) begin
        bpop(b);
        check("R3 tx order", {24'd0, b}, {24'd0, txq.pop_front()});
      end
    end
    hrd(3'd4, rd);
    check("R5 tx drain sticky", {31'd0, rd[3]}, {31'd0, (tl != 0)});
    hwr(3'd4, 32'h1c);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    seed_v = $urandom(32'h5eed_0017);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    hrd(3'd4, rd); check("R11 raw after reset", rd, 0);
    hrd(3'd3, rd); check("R11 stat after reset", rd, 0);
    hrd(3'd5, rd); check("R11 enable after reset", rd, 0);
    hrd(3'd0, rd); check("R11 cfg after reset", rd, 0);
    check("R11 irq low", {31'd0, irq}, 0);

    // R4 directed: exact multiple, empty at end -> no drain
    rx_round(3, 8);
    rx_round(0, 1);
    for (int r = 0; r < 6; r++) rx_round(int'($urandom % 8), int'($urandom % 20) + 1);

    // R7 empty read
    hrd(3'd2, rd);
    check("R7 empty read returns 0", rd, 0);
    hrd(3'd4, rd);
    check("R7 empty read sets error", {31'd0, rd[4]}, 1);
    hwr(3'd4, 32'h10);
    hrd(3'd4, rd);
    check("R8 error cleared", {31'd0, rd[4]}, 0);

    // R5 directed: exact multiple, short count, then random
    tx_round(3, 12);
    tx_round(7, 3);
    tx_round(4, 70);
    for (int r = 0; r < 6; r++) tx_round(int'($urandom % 8), int'($urandom % 40) + 1);

    // R5 target mode: no transmit drain
    hwr(3'd0, {18'd0, 6'd3, 8'd0});
    hwr(3'd1, 5);
    for (int i = 0; i < 4; i++) hwr(3'd2, i);
    repeat (2) @(negedge clk);
    hrd(3'd4, rd);
    check("R5 no drain in target mode", {31'd0, rd[3]}, 0);
    begin
      logic [7:0] b;
      for (int i = 0; i < 4; i++) bpop(b);
    end

    // R7 full write dropped
    hwr(3'd1, 100);
    for (int i = 0; i < 33; i++) hwr(3'd2, 8'(i + 1));
    hrd(3'd4, rd);
    check("R7 full write sets error", {31'd0, rd[4]}, 1);
    hrd(3'd3, rd);
    check("R6 left stops on dropped write", {16'd0, rd[31:16]}, 68);
    begin
      logic [7:0] b;
      for (int i = 0; i < 32; i++) begin
        bpop(b);
        check("R3 full fifo order", {24'd0, b}, i + 1);
      end
    end
    check("R7 extra byte dropped", {31'd0, tx_empty}, 1);

    // R9 interrupt gating
    check("R9 irq masked", {31'd0, irq}, 0);
    hwr(3'd5, 32'h10);
    #2 check("R9 irq with enable", {31'd0, irq}, 1);
    hrd(3'd5, rd);
    check("R9 enable readback", rd, 32'h10);
    hwr(3'd4, 32'h10);
    #2 check("R9 irq after clear", {31'd0, irq}, 0);
    hwr(3'd5, 0);

    // R10 flush
    for (int i = 0; i < 3; i++) bpush(8'(i));
    for (int i = 0; i < 3; i++) hwr(3'd2, i);
    hwr(3'd0, 32'h8000_0000);
    hrd(3'd3, rd);
    check("R10 rx empty after flush", {26'd0, rd[5:0]}, 0);
    check("R10 count kept", {16'd0, rd[31:16]}, 65);
    check("R10 tx empty after flush", {31'd0, tx_empty}, 1);

    done = 1;
    summary();
  end
endmodule